// File: doc/BRIEF.md
# Ethernet MAC Control Register File

This block is the bus-facing configuration store of an Ethernet MAC. A host reaches it through a 32-bit single-access bus slave with word addressing and byte-lane selects. It holds twenty 32-bit words: the operating mode, the interrupt mask, three inter-packet gap settings, the packet length limits, the collision setup, the transmit descriptor count, the control-frame mode, the management-interface mode, command, address and write data, the station address and the multicast hash. Every stored word drives an output port of the same name, so the rest of the MAC reads its configuration straight from the block.

Each word has its own reset value and its own mask of writable bits. Bits outside the mask always read as zero. Three words are read-only views of status that the MAC supplies on input ports, and bus writes to them do nothing. The management command word stores nothing: a write produces a one-clock pulse on its command bits. The descriptor count word range-checks every write and drops any write that would take it past its limit, keeping its old value.

Top module: `eth_mac_regbank`

## Requirements
- R1: For every access (cyc_i and stb_i high while ack_o is low), ack_o is high for exactly the next cycle. ack_o stays low in any cycle that follows a cycle without a strobe.
- R2: After reset the words read back as follows, by word address: 0 = 0x0000A800, 3 = 0x12, 4 = 0x0C, 5 = 0x12, 6 = 0x00400600, 7 = 0x000F003F, 8 = 0x40, 10 = 0x64. Words 2, 9, 12, 13, 16, 17, 18 and 19 read 0.
- R3: The writable masks are: word 0 0x1FFFF; words 2 to 5 0x7F; word 6 all bits; word 7 0x000F003F; word 8 0xFF; word 9 0x7; word 10 0x3FF; word 12 0x1F1F; word 13 0xFFFF; words 16, 18 and 19 all bits; word 17 0xFFFF. Bits outside a mask read 0 whatever was written.
- R4: A write updates byte k (bits 8k+7 to 8k) only when sel_i[k] is 1. The other bytes keep their old value.
- R5: For word 8, the byte-lane merge of the old value and the write data is compared with 0x80 before masking. A merged value above 0x80 is dropped and the old value stays. Values up to and including 0x80 are stored.
- R6: Words 1, 14 and 15 read irq_src_i, mii_rdata_i and mii_status_i at the time of the access. Writes to them change no output.
- R7: A write to word 11 with sel_i[0] set drives dat_i[2:0] on mii_cmd_o for exactly one clock, the cycle in which ack_o is high. mii_cmd_o is 0 otherwise, and a read of word 11 returns 0.
- R8: Raising rst_i sets every stored word and mii_cmd_o to its reset value at once, without waiting for a clock edge.
- R9: Word addresses 20 to 31 are acknowledged, read as 0, and a write to them changes no output.
- R10: Every stored word's output port always equals the value a read of that word returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| cyc_i | input | 1 | Bus cycle valid |
| stb_i | input | 1 | Access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | ADDR_W | Word address (byte offset divided by 4) |
| sel_i | input | 4 | Byte-lane enables |
| dat_i | input | 32 | Write data |
| dat_o | output | 32 | Read data, valid with ack_o |
| ack_o | output | 1 | Access acknowledge |
| irq_src_i | input | 32 | Interrupt source status (word 1) |
| mii_rdata_i | input | 32 | Management read data (word 14) |
| mii_status_i | input | 32 | Management status (word 15) |
| mode_o | output | 32 | Word 0 |
| int_mask_o | output | 32 | Word 2 |
| gap_b2b_o | output | 32 | Word 3 |
| gap_nb1_o | output | 32 | Word 4 |
| gap_nb2_o | output | 32 | Word 5 |
| pkt_len_o | output | 32 | Word 6 |
| coll_cfg_o | output | 32 | Word 7 |
| txbd_cnt_o | output | 32 | Word 8 |
| ctrl_mode_o | output | 32 | Word 9 |
| mii_mode_o | output | 32 | Word 10 |
| mii_cmd_o | output | 3 | Word 11 command pulses |
| mii_addr_o | output | 32 | Word 12 |
| mii_wdata_o | output | 32 | Word 13 |
| sta_addr0_o | output | 32 | Word 16 |
| sta_addr1_o | output | 32 | Word 17 |
| hash0_o | output | 32 | Word 18 |
| hash1_o | output | 32 | Word 19 |

## Verification
Byte-lane gating and the descriptor-count range check act in the same write. The range check must judge the merged word, not the bytes that were sent. The bench sends partial writes to word 8: a low-byte-only 0x81, a second-byte-only write that lifts the merged value above the limit, and a low-byte 0x80 that lands exactly on it. Each time the bench model works out the merged value first and then decides acceptance, and the result is judged both on txbd_cnt_o every clock and by readback.

// File: rtl/eth_regbank_pkg.sv
`timescale 1ns/1ps
package eth_regbank_pkg;

   localparam int NREG  = 20;
   localparam int REG_W = 32;

   typedef enum logic [1:0] {RK_RW, RK_RO, RK_CMD, RK_LIM} reg_kind_e;

   localparam int IX_MODE    = 0;
   localparam int IX_INTSRC  = 1;
   localparam int IX_MIICMD  = 11;
   localparam int IX_MIIRXD  = 14;
   localparam int IX_MIISTAT = 15;

   function automatic reg_kind_e reg_kind(input int ix);
      case (ix)
         IX_INTSRC, IX_MIIRXD, IX_MIISTAT: return RK_RO;
         IX_MIICMD:                        return RK_CMD;
         8:                                return RK_LIM;
         default:                          return RK_RW;
      endcase
   endfunction

   function automatic logic [REG_W-1:0] reg_mask(input int ix);
      case (ix)
         0:             return 32'h0001_FFFF;
         2, 3, 4, 5:    return 32'h0000_007F;
         6, 16, 18, 19: return 32'hFFFF_FFFF;
         7:             return 32'h000F_003F;
         8:             return 32'h0000_00FF;
         9:             return 32'h0000_0007;
         10:            return 32'h0000_03FF;
         12:            return 32'h0000_1F1F;
         13, 17:        return 32'h0000_FFFF;
         default:       return 32'h0000_0000;
      endcase
   endfunction

   function automatic logic [REG_W-1:0] reg_rst(input int ix);
      case (ix)
         0:       return 32'h0000_A800;
         3, 5:    return 32'h0000_0012;
         4:       return 32'h0000_000C;
         6:       return 32'h0040_0600;
         7:       return 32'h000F_003F;
         8:       return 32'h0000_0040;
         10:      return 32'h0000_0064;
         default: return 32'h0000_0000;
      endcase
   endfunction

endpackage

// File: rtl/eth_regbank_bus.sv
`timescale 1ns/1ps
module eth_regbank_bus (
   input  logic clk_i,
   input  logic rst_i,
   input  logic cyc_i,
   input  logic stb_i,
   input  logic we_i,
   output logic ack_o,
   output logic wr_o,
   output logic rd_o
);

   logic acc;

   assign acc  = cyc_i & stb_i & ~ack_o;
   assign wr_o = acc & we_i;
   assign rd_o = acc & ~we_i;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) ack_o <= 1'b0;
      else       ack_o <= acc;
   end

   AST_ACK_FOLLOWS_STB: assert property (@(posedge clk_i) disable iff (rst_i)
      (cyc_i && stb_i && !ack_o) |=> ack_o); // R1
   AST_NO_ACK_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
      !(cyc_i && stb_i) |=> !ack_o); // R1

endmodule

// File: rtl/eth_regbank_cell.sv
`timescale 1ns/1ps
module eth_regbank_cell #(
   parameter int           W      = 32,
   parameter logic [W-1:0] RST    = '0,
   parameter logic [W-1:0] MASK   = '1,
   parameter bit           LIM_EN = 1'b0,
   parameter logic [W-1:0] LIM    = '0
) (
   input  logic           clk_i,
   input  logic           rst_i,
   input  logic           we_i,
   input  logic [W/8-1:0] sel_i,
   input  logic [W-1:0]   d_i,
   output logic [W-1:0]   q_o
);

   localparam int NB = W / 8;

   logic [W-1:0] merged;
   logic         accept;

   for (genvar b = 0; b < NB; b++) begin : g_lane
      assign merged[8*b +: 8] = sel_i[b] ? d_i[8*b +: 8] : q_o[8*b +: 8];
   end

   if (LIM_EN) begin : g_lim
      assign accept = (merged <= LIM);
   end else begin : g_nolim
      assign accept = 1'b1;
   end

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)                q_o <= RST & MASK;
      else if (we_i && accept)  q_o <= merged & MASK;
   end

   AST_MASKED_BITS_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
      (q_o & ~MASK) == '0); // R3

   if (LIM_EN) begin : g_lim_chk
      AST_TXBD_IN_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
         q_o <= LIM); // R5
      AST_TXBD_REJECT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
         (we_i && merged > LIM) |=> $stable(q_o)); // R5
   end

endmodule

// File: rtl/eth_regbank_pulse.sv
`timescale 1ns/1ps
module eth_regbank_pulse #(
   parameter int CW = 3
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          fire_i,
   input  logic          lane_i,
   input  logic [CW-1:0] d_i,
   output logic [CW-1:0] q_o
);

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)                  q_o <= '0;
      else if (fire_i && lane_i)  q_o <= d_i;
      else                        q_o <= '0;
   end

   AST_CMD_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
      (q_o != '0 && !fire_i) |=> (q_o == '0)); // R7

endmodule

// File: rtl/eth_mac_regbank.sv
`timescale 1ns/1ps
module eth_mac_regbank
   import eth_regbank_pkg::*;
#(
   parameter int          ADDR_W   = 5,
   parameter int          DATA_W   = 32,
   parameter int          CMD_W    = 3,
   parameter logic [31:0] TXBD_MAX = 32'h80
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              cyc_i,
   input  logic              stb_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] adr_i,
   input  logic [3:0]        sel_i,
   input  logic [31:0]       dat_i,
   output logic [31:0]       dat_o,
   output logic              ack_o,
   input  logic [31:0]       irq_src_i,
   input  logic [31:0]       mii_rdata_i,
   input  logic [31:0]       mii_status_i,
   output logic [31:0]       mode_o,
   output logic [31:0]       int_mask_o,
   output logic [31:0]       gap_b2b_o,
   output logic [31:0]       gap_nb1_o,
   output logic [31:0]       gap_nb2_o,
   output logic [31:0]       pkt_len_o,
   output logic [31:0]       coll_cfg_o,
   output logic [31:0]       txbd_cnt_o,
   output logic [31:0]       ctrl_mode_o,
   output logic [31:0]       mii_mode_o,
   output logic [2:0]        mii_cmd_o,
   output logic [31:0]       mii_addr_o,
   output logic [31:0]       mii_wdata_o,
   output logic [31:0]       sta_addr0_o,
   output logic [31:0]       sta_addr1_o,
   output logic [31:0]       hash0_o,
   output logic [31:0]       hash1_o
);

   localparam int NBYTE = DATA_W / 8;

   if (DATA_W != REG_W) begin : g_bad_w
      $error("eth_mac_regbank: DATA_W must equal the register width");
   end
   if ((1 << ADDR_W) < NREG) begin : g_bad_a
      $error("eth_mac_regbank: ADDR_W too small for the register window");
   end
   if (TXBD_MAX > 32'hFF) begin : g_bad_lim
      $error("eth_mac_regbank: TXBD_MAX exceeds the count field");
   end
   if (CMD_W != 3) begin : g_bad_cmd
      $error("eth_mac_regbank: CMD_W must be 3");
   end

   logic              wr, rd;
   logic [DATA_W-1:0] regq [NREG];
   logic [DATA_W-1:0] rd_val;

   eth_regbank_bus u_bus (
      .clk_i (clk_i), .rst_i (rst_i), .cyc_i (cyc_i), .stb_i (stb_i),
      .we_i  (we_i),  .ack_o (ack_o), .wr_o  (wr),    .rd_o  (rd)
   );

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (reg_kind(g) == RK_RW || reg_kind(g) == RK_LIM) begin : g_store
         eth_regbank_cell #(
            .W      (DATA_W),
            .RST    (reg_rst(g)),
            .MASK   (reg_mask(g)),
            .LIM_EN (reg_kind(g) == RK_LIM),
            .LIM    (TXBD_MAX)
         ) u_cell (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .we_i  (wr && (adr_i == ADDR_W'(g))),
            .sel_i (sel_i[NBYTE-1:0]),
            .d_i   (dat_i),
            .q_o   (regq[g])
         );
      end else if (reg_kind(g) == RK_RO) begin : g_ro
         if (g == IX_INTSRC) begin : g_irq
            assign regq[g] = irq_src_i;
         end else if (g == IX_MIIRXD) begin : g_rxd
            assign regq[g] = mii_rdata_i;
         end else begin : g_sts
            assign regq[g] = mii_status_i;
         end
      end else begin : g_cmd
         assign regq[g] = '0;
      end
   end

   eth_regbank_pulse #(.CW(CMD_W)) u_cmd (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .fire_i (wr && (adr_i == ADDR_W'(IX_MIICMD))),
      .lane_i (sel_i[0]),
      .d_i    (dat_i[CMD_W-1:0]),
      .q_o    (mii_cmd_o)
   );

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < NREG; i++) begin
         if (adr_i == ADDR_W'(i)) rd_val = regq[i];
      end
   end

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)   dat_o <= '0;
      else if (rd) dat_o <= rd_val;
   end

   assign mode_o      = regq[IX_MODE];
   assign int_mask_o  = regq[2];
   assign gap_b2b_o   = regq[3];
   assign gap_nb1_o   = regq[4];
   assign gap_nb2_o   = regq[5];
   assign pkt_len_o   = regq[6];
   assign coll_cfg_o  = regq[7];
   assign txbd_cnt_o  = regq[8];
   assign ctrl_mode_o = regq[9];
   assign mii_mode_o  = regq[10];
   assign mii_addr_o  = regq[12];
   assign mii_wdata_o = regq[13];
   assign sta_addr0_o = regq[16];
   assign sta_addr1_o = regq[17];
   assign hash0_o     = regq[18];
   assign hash1_o     = regq[19];

   AST_READ_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
      !rd |=> $stable(dat_o)); // R10
   AST_OOR_READ_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd && adr_i >= ADDR_W'(NREG)) |=> (dat_o == '0)); // R9

endmodule

// File: tb/eth_mac_regbank_tb_top.sv
`timescale 1ns/1ps
module eth_mac_regbank_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
   logic [4:0]  adr = '0;
   logic [3:0]  sel = '0;
   logic [31:0] wdat = '0;
   logic [31:0] dat_o;
   logic        ack_o;
   logic [31:0] sts_irq = '0, sts_rxd = '0, sts_st = '0;
   logic [31:0] mode_o, int_mask_o, gap_b2b_o, gap_nb1_o, gap_nb2_o, pkt_len_o,
                coll_cfg_o, txbd_cnt_o, ctrl_mode_o, mii_mode_o, mii_addr_o,
                mii_wdata_o, sta_addr0_o, sta_addr1_o, hash0_o, hash1_o;
   logic [2:0]  mii_cmd_o;

   int total = 0;
   int bad   = 0;
   bit run   = 0;

   always #2 clk = ~clk;

   eth_mac_regbank dut_i (
      .clk_i(clk), .rst_i(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we),
      .adr_i(adr), .sel_i(sel), .dat_i(wdat), .dat_o(dat_o), .ack_o(ack_o),
      .irq_src_i(sts_irq), .mii_rdata_i(sts_rxd), .mii_status_i(sts_st),
      .mode_o(mode_o), .int_mask_o(int_mask_o), .gap_b2b_o(gap_b2b_o),
      .gap_nb1_o(gap_nb1_o), .gap_nb2_o(gap_nb2_o), .pkt_len_o(pkt_len_o),
      .coll_cfg_o(coll_cfg_o), .txbd_cnt_o(txbd_cnt_o), .ctrl_mode_o(ctrl_mode_o),
      .mii_mode_o(mii_mode_o), .mii_cmd_o(mii_cmd_o), .mii_addr_o(mii_addr_o),
      .mii_wdata_o(mii_wdata_o), .sta_addr0_o(sta_addr0_o), .sta_addr1_o(sta_addr1_o),
      .hash0_o(hash0_o), .hash1_o(hash1_o)
   );

   // kind: 0 stored, 1 read-only, 2 command, 3 range-checked
   function automatic int tkind(input int i);
      if (i == 1 || i == 14 || i == 15) return 1;
      if (i == 11) return 2;
      if (i == 8)  return 3;
      return 0;
   endfunction

   function automatic logic [31:0] tmask(input int i);
      logic [31:0] t [20] = '{32'h1FFFF, 0, 32'h7F, 32'h7F, 32'h7F, 32'h7F, 32'hFFFFFFFF,
                              32'h000F003F, 32'hFF, 32'h7, 32'h3FF, 0, 32'h1F1F, 32'hFFFF,
                              0, 0, 32'hFFFFFFFF, 32'hFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF};
      return t[i];
   endfunction

   function automatic logic [31:0] trst(input int i);
      logic [31:0] t [20] = '{32'hA800, 0, 0, 32'h12, 32'h0C, 32'h12, 32'h00400600,
                              32'h000F003F, 32'h40, 0, 32'h64, 0, 0, 0, 0, 0, 0, 0, 0, 0};
      return t[i];
   endfunction

   logic [31:0] mdl [20];
   logic [2:0]  cmd_exp = '0;
   logic        ack_exp = 1'b0;
   bit          pend_acc = 0, pend_wr = 0;
   int          pend_adr = 0;
   logic [31:0] pend_dat = '0;
   logic [3:0]  pend_sel = '0;

   function automatic logic [31:0] port_val(input int i);
      case (i)
         0: return mode_o;       2: return int_mask_o;   3: return gap_b2b_o;
         4: return gap_nb1_o;    5: return gap_nb2_o;    6: return pkt_len_o;
         7: return coll_cfg_o;   8: return txbd_cnt_o;   9: return ctrl_mode_o;
         10: return mii_mode_o;  12: return mii_addr_o;  13: return mii_wdata_o;
         16: return sta_addr0_o; 17: return sta_addr1_o; 18: return hash0_o;
         19: return hash1_o;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] rd_exp(input int a);
      if (a >= 20) return 32'h0;
      case (tkind(a))
         1: return (a == 1) ? sts_irq : (a == 14) ? sts_rxd : sts_st;
         2: return 32'h0;
         default: return mdl[a];
      endcase
   endfunction

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 20; i++) mdl[i] = trst(i);
      cmd_exp = '0; ack_exp = 1'b0; pend_acc = 0; pend_wr = 0;
   endtask

   task automatic model_write(input int a, input logic [31:0] d, input logic [3:0] s);
      logic [31:0] m;
      if (a >= 20) return;
      if (tkind(a) == 2) begin
         if (s[0]) cmd_exp = d[2:0];
         return;
      end
      if (tkind(a) == 1) return;
      m = mdl[a];
      for (int b = 0; b < 4; b++) if (s[b]) m[8*b +: 8] = d[8*b +: 8];
      if (tkind(a) == 3 && m > 32'h80) return;
      mdl[a] = m & tmask(a);
   endtask

   // model advances just after each rising edge
   always @(posedge clk) begin
      #1;
      if (!rst) begin
         ack_exp = pend_acc;
         cmd_exp = '0;
         if (pend_wr) model_write(pend_adr, pend_dat, pend_sel);
         pend_acc = 0; pend_wr = 0;
      end
   end

   // per-clock comparison of every output against the model
   always @(negedge clk) begin
      if (run && !rst) begin
         chk(ack_o == ack_exp, "R1 ack timing", {31'b0, ack_o}, {31'b0, ack_exp});
         chk(mii_cmd_o == cmd_exp, "R7 command pulse", {29'b0, mii_cmd_o}, {29'b0, cmd_exp});
         for (int i = 0; i < 20; i++)
            if (tkind(i) == 0 || tkind(i) == 3)
               chk(port_val(i) == mdl[i], "R10 port vs model", port_val(i), mdl[i]);
      end
   end

   task automatic bus_write(input int a, input logic [31:0] d, input logic [3:0] s);
      @(negedge clk);
      cyc = 1; stb = 1; we = 1; adr = a[4:0]; wdat = d; sel = s;
      pend_acc = 1; pend_wr = 1; pend_adr = a; pend_dat = d; pend_sel = s;
      @(negedge clk);
      cyc = 0; stb = 0; we = 0;
   endtask

   task automatic bus_read(input int a, input string rq);
      logic [31:0] e;
      @(negedge clk);
      cyc = 1; stb = 1; we = 0; adr = a[4:0]; sel = 4'hF;
      pend_acc = 1;
      @(negedge clk);
      e = rd_exp(a);
      chk(dat_o == e, rq, dat_o, e);
      cyc = 0; stb = 0;
   endtask

   task automatic check_reset_ports(input string rq);
      for (int i = 0; i < 20; i++)
         if (tkind(i) == 0 || tkind(i) == 3)
            chk(port_val(i) == trst(i), rq, port_val(i), trst(i));
      chk(mii_cmd_o == 3'b0, rq, {29'b0, mii_cmd_o}, 32'h0);
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      finish_run();
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      check_reset_ports("R2 reset port value");
      rst = 0;
      run = 1;

      // R2: reset readback of every word
      for (int a = 0; a < 20; a++) bus_read(a, "R2 reset readback");

      // R3 R6 R9: all ones everywhere
      for (int a = 0; a < 32; a++) bus_write(a, 32'hFFFF_FFFF, 4'hF);
      for (int a = 0; a < 32; a++) bus_read(a, "R3 R6 R9 all-ones readback");

      // R3: inverse of reset values
      for (int a = 0; a < 20; a++) if (a != 8) bus_write(a, ~trst(a), 4'hF);
      for (int a = 0; a < 20; a++) bus_read(a, "R3 inverse readback");

      // R3: walking one on a few masked words
      for (int b = 0; b < 32; b++) begin
         bus_write(0, 32'h1 << b, 4'hF);
         bus_write(12, 32'h1 << b, 4'hF);
         bus_read(0, "R3 walking one mode");
         bus_read(12, "R3 walking one mii addr");
      end

      // R4: byte lanes
      bus_write(6, 32'h1122_3344, 4'hF);
      bus_write(6, 32'hAABB_CCDD, 4'b0101);
      bus_read(6, "R4 lanes 0 and 2");
      bus_write(16, 32'h0, 4'hF);
      bus_write(16, 32'hDEAD_BEEF, 4'b1000);
      bus_read(16, "R4 lane 3 only");
      bus_write(16, 32'h1234_5678, 4'b0000);
      bus_read(16, "R4 no lanes");

      // R5: descriptor count limits, with lanes
      bus_write(8, 32'h80, 4'hF);        bus_read(8, "R5 accept limit");
      bus_write(8, 32'h7F, 4'hF);        bus_read(8, "R5 accept below limit");
      bus_write(8, 32'h81, 4'hF);        bus_read(8, "R5 reject above limit");
      bus_write(8, 32'hFFFF_FFFF, 4'hF); bus_read(8, "R5 reject all ones");
      bus_write(8, 32'h0000_0081, 4'b0001); bus_read(8, "R5 reject low lane");
      bus_write(8, 32'h0000_0100, 4'b0010); bus_read(8, "R5 reject merged upper lane");
      bus_write(8, 32'h0000_FF80, 4'b0001); bus_read(8, "R5 accept low lane at limit");
      bus_write(8, 32'h0, 4'hF);         bus_read(8, "R5 accept zero");

      // R6: read-only words track inputs, ignore writes
      sts_irq = 32'h0000_005A; sts_rxd = 32'h0000_C3C3; sts_st = 32'h0000_0005;
      bus_read(1, "R6 irq source");
      bus_read(14, "R6 mii read data");
      bus_read(15, "R6 mii status");
      bus_write(1, 32'h0, 4'hF);
      bus_write(15, 32'hFFFF_FFFF, 4'hF);
      bus_read(1, "R6 irq after write");
      bus_read(15, "R6 status after write");

      // R7: command pulses
      bus_write(11, 32'h5, 4'b0001);
      bus_read(11, "R7 command reads zero");
      bus_write(11, 32'h7, 4'b0010);
      bus_write(11, 32'h2, 4'hF);
      bus_write(11, 32'h3, 4'b0001);
      bus_write(11, 32'h4, 4'b0001);

      // R9: out-of-window writes leave stored words intact
      bus_write(20, 32'h0, 4'hF);
      bus_write(31, 32'h0, 4'hF);
      bus_read(25, "R9 out-of-window read");
      bus_read(3, "R9 word 3 untouched");

      // R8: asynchronous reset between edges
      bus_write(9, 32'h5, 4'hF);
      bus_write(17, 32'h1234, 4'hF);
      @(negedge clk);
      #0.5;
      rst = 1;
      #0.5;
      check_reset_ports("R8 async reset");
      model_reset();
      repeat (2) @(negedge clk);
      rst = 0;
      bus_read(9, "R8 readback after reset");
      bus_read(0, "R8 mode after reset");

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule